// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes an 8-bit controller core from normal execution into an interrupt handler. While idle it watches a vector of pending hardware requests, a reset request, the global interrupt enable flag and a flag saying that a skip is in flight. When it accepts a request, it does four things:

- It picks the winning source.
- It clears the global enable flag and that source's pending bit, both in the same cycle.
- It writes the return program counter onto a byte-wide stack in data memory, one byte per cycle.
- It hands the core a new PC taken from the vector table and the stack pointer as it stands after the pushes.

The core pipeline stays stalled while the busy output is high. The number of return-address bytes is a parameter (1, 2 or 3). A second parameter says whether the core has long jump/call. That choice sets the spacing of the vector table entries to 2 words when present and 1 word when absent.

The state machine has three states: `ST_IDLE`, `ST_PUSH` and `ST_LOAD`.

- ST_IDLE → ST_PUSH on acceptance. The PC, SP and target are latched at this point.
- ST_PUSH → ST_PUSH while return bytes remain.
- ST_PUSH → ST_LOAD after the last byte is written.
- ST_LOAD → ST_IDLE unconditionally, after presenting the new PC and SP for one cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: While `gie_i` is 0, no request is accepted: `busy_o`, `gie_clr_o`, `pend_clr_o` and `mem_we_o` stay 0.
- R2: A reset request has priority over hardware requests in the same cycle. It targets vector 0, and `pend_clr_o` stays 0 when it is taken.
- R3: Among the set bits of `pend_i`, the lowest index wins. In the acceptance cycle `pend_clr_o` is one-hot at that bit and 0 everywhere else.
- R4: Hardware source n targets vector n+1. `new_pc_o` equals VEC_BASE + vector × entry, where entry is 2 when LONG_JUMP=1 and 1 otherwise.
- R5: After acceptance, PC_BYTES consecutive cycles each write one byte with `mem_we_o`=1. The bytes go least significant first, to addresses SP, SP-1, SP-2, and the addresses wrap modulo 2^SP_W.
- R6: In the load cycle, `new_sp_o` equals the accepted SP minus PC_BYTES, modulo 2^SP_W.
- R7: `gie_clr_o` is a one-cycle pulse in the acceptance cycle. The acceptance cycle is the idle cycle in which the request is seen.
- R8: While `skip_pend_i` is 1, no request is accepted.
- R9: `busy_o` is 1 from the cycle after acceptance through the load cycle. `load_o` is a one-cycle pulse in the cycle right after the last push. Inputs seen while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_SRC | Pending hardware request bits |
| rst_req_i | input | 1 | Reset request |
| gie_i | input | 1 | Global interrupt enable flag |
| skip_pend_i | input | 1 | A skip is in flight, so acceptance is blocked |
| pc_i | input | PC_W | Return program counter (word address) |
| sp_i | input | SP_W | Current stack pointer |
| mem_we_o | output | 1 | Data memory byte write strobe |
| mem_addr_o | output | SP_W | Data memory write address |
| mem_wdata_o | output | 8 | Data memory write byte |
| busy_o | output | 1 | Sequence in progress, so the pipeline stalls |
| gie_clr_o | output | 1 | Clear the global enable flag |
| pend_clr_o | output | NUM_SRC | Clear the winning pending bit |
| load_o | output | 1 | Load `new_pc_o` and `new_sp_o` |
| new_pc_o | output | PC_W | Handler entry address |
| new_sp_o | output | SP_W | Stack pointer after the pushes |

## Verification
The bench goes after these corner cases:

- **Several pending bits at once.** A design that picks the highest bit, or clears more than one bit, shows a wrong one-hot clear or a wrong vector.
- **A reset request alongside hardware bits.** A design that lets hardware win jumps past vector 0 and clears a pending bit.
- **Requests with the enable flag low, or with a skip pending.** A design that ignores either gate starts a stack write it must not make.
- **A stack pointer near zero.** Wrap errors show as a bad address or a bad final SP.
- **Back-to-back entries.** An off-by-one in the byte count shows as a missing byte, an extra byte or a late PC load.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Lowest-index-wins picker over the pending vector.
module irq_prio_pick #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [NUM_SRC-1:0] grant,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
        any = found;
    end
endmodule

// File: rtl/irq_vec_calc.sv
// Handler address: base + vector * entry size (entry size set by LONG_JUMP).
module irq_vec_calc #(
    parameter int          NUM_SRC   = 8,
    parameter int          PC_W      = 22,
    parameter logic [31:0] VEC_BASE  = 32'h0,
    parameter bit          LONG_JUMP = 1'b1,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             is_reset,
    input  logic [IDX_W-1:0] idx,
    output logic [PC_W-1:0]  target
);
    logic [PC_W-1:0] vec_num;
    logic [PC_W-1:0] offset;

    always_comb begin
        if (is_reset) vec_num = '0;
        else          vec_num = PC_W'(idx) + PC_W'(1);
    end

    generate
        if (LONG_JUMP) begin : g_two_word
            assign offset = vec_num << 1;
        end else begin : g_one_word
            assign offset = vec_num;
        end
    endgenerate

    assign target = PC_W'(VEC_BASE) + offset;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int          NUM_SRC   = 8,
    parameter int          PC_BYTES  = 3,
    parameter int          PC_W      = 22,
    parameter int          SP_W      = 16,
    parameter logic [31:0] VEC_BASE  = 32'h0,
    parameter bit          LONG_JUMP = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               rst_req_i,
    input  logic               gie_i,
    input  logic               skip_pend_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [SP_W-1:0]    sp_i,
    output logic               mem_we_o,
    output logic [SP_W-1:0]    mem_addr_o,
    output logic [7:0]         mem_wdata_o,
    output logic               busy_o,
    output logic               gie_clr_o,
    output logic [NUM_SRC-1:0] pend_clr_o,
    output logic               load_o,
    output logic [PC_W-1:0]    new_pc_o,
    output logic [SP_W-1:0]    new_sp_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int RET_W = 8 * PC_BYTES;
    localparam int CNT_W = 2;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PC_BYTES - 1);

    seq_state_e         state_q, state_d;
    logic [RET_W-1:0]   ret_q;
    logic [SP_W-1:0]    sp_q;
    logic [PC_W-1:0]    tgt_q;
    logic [CNT_W-1:0]   cnt_q;

    logic               hw_any;
    logic [NUM_SRC-1:0] hw_grant;
    logic [IDX_W-1:0]   hw_idx;
    logic [PC_W-1:0]    target;
    logic               accept;

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req   (pend_i),
        .any   (hw_any),
        .grant (hw_grant),
        .idx   (hw_idx)
    );

    irq_vec_calc #(
        .NUM_SRC(NUM_SRC), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .LONG_JUMP(LONG_JUMP)
    ) u_vec (
        .is_reset (rst_req_i),
        .idx      (hw_idx),
        .target   (target)
    );

    assign accept = (state_q == ST_IDLE) && gie_i && !skip_pend_i
                    && (rst_req_i || hw_any);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_PUSH;
            ST_PUSH: if (cnt_q == LAST_CNT) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= '0;
            sp_q    <= '0;
            tgt_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ret_q <= RET_W'(pc_i);
                sp_q  <= sp_i;
                tgt_q <= target;
                cnt_q <= '0;
            end else if (state_q == ST_PUSH) begin
                ret_q <= ret_q >> 8;
                sp_q  <= sp_q - SP_W'(1);
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        mem_we_o    = 1'b0;
        mem_addr_o  = sp_q;
        mem_wdata_o = ret_q[7:0];
        busy_o      = 1'b0;
        gie_clr_o   = 1'b0;
        pend_clr_o  = '0;
        load_o      = 1'b0;
        new_pc_o    = tgt_q;
        new_sp_o    = sp_q;
        unique case (state_q)
            ST_IDLE: begin
                gie_clr_o  = accept;
                pend_clr_o = (accept && !rst_req_i) ? hw_grant : '0;
            end
            ST_PUSH: begin
                busy_o   = 1'b1;
                mem_we_o = 1'b1;
            end
            ST_LOAD: begin
                busy_o = 1'b1;
                load_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: enable flag low keeps the sequencer idle
    a_r1_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !gie_i) |=> !busy_o);

    // R8: a pending skip keeps the sequencer idle
    a_r8_skip_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && skip_pend_i) |=> !busy_o);

    // R3: at most one pending bit cleared, and only a pending one
    a_r3_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr_o) && ((pend_clr_o & ~pend_i) == '0));

    // R5: consecutive pushes step the address down by one
    a_r5_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - SP_W'(1)));

    // R7: clearing the enable flag starts a sequence
    a_r7_clear_starts: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_o |=> busy_o);

    // R9: PC load follows a push and lasts one cycle
    a_r9_load_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ($past(mem_we_o) && busy_o));
    a_r9_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 8;
    localparam int PB  = 3;
    localparam int PCW = 22;
    localparam int SPW = 16;
    localparam logic [31:0] VB = 32'h0;
    localparam bit LJ = 1'b1;

    logic clk = 0, rst_n = 0;
    logic [NS-1:0] pend = '0;
    logic rst_req = 0, gie = 0, skip = 0;
    logic [PCW-1:0] pc = '0;
    logic [SPW-1:0] sp = '0;
    logic mem_we, busy, gie_clr, load;
    logic [SPW-1:0] mem_addr, new_sp;
    logic [7:0] mem_wdata;
    logic [NS-1:0] pend_clr;
    logic [PCW-1:0] new_pc;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    int m_phase = 0;
    int m_pc = 0, m_sp = 0, m_tgt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq #(.NUM_SRC(NS), .PC_BYTES(PB), .PC_W(PCW), .SP_W(SPW),
                    .VEC_BASE(VB), .LONG_JUMP(LJ)) i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .rst_req_i(rst_req),
        .gie_i(gie), .skip_pend_i(skip), .pc_i(pc), .sp_i(sp),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .busy_o(busy), .gie_clr_o(gie_clr), .pend_clr_o(pend_clr),
        .load_o(load), .new_pc_o(new_pc), .new_sp_o(new_sp));

    task automatic chk(string req, string what, longint got, longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // one clock: compare outputs with the model, then advance the model
    task automatic cyc();
        bit acc;
        int low;
        string gate_req;
        #1;
        acc = 0;
        low = -1;
        for (int i = NS - 1; i >= 0; i--) if (pend[i]) low = i;
        if (m_phase == 0) begin
            acc = gie && !skip && (rst_req || low >= 0);
            gate_req = !gie ? "R1" : (skip ? "R8" : "R7");
            chk(gate_req, "gie_clr", gie_clr, acc);
            chk("R9", "busy", busy, 0);
            chk(gate_req, "mem_we", mem_we, 0);
            chk("R9", "load", load, 0);
            if (acc && !rst_req) chk("R3", "pend_clr", pend_clr, 1 << low);
            else chk(rst_req ? "R2" : "R3", "pend_clr", pend_clr, 0);
        end else if (m_phase <= PB) begin
            chk("R9", "busy", busy, 1);
            chk("R5", "mem_we", mem_we, 1);
            chk("R5", "mem_addr", mem_addr, (m_sp - (m_phase - 1)) & 16'hFFFF);
            chk("R5", "mem_wdata", mem_wdata, (m_pc >> (8 * (m_phase - 1))) & 8'hFF);
            chk("R9", "load", load, 0);
            chk("R7", "gie_clr", gie_clr, 0);
        end else begin
            chk("R9", "busy", busy, 1);
            chk("R9", "load", load, 1);
            chk("R5", "mem_we", mem_we, 0);
            chk("R4", "new_pc", new_pc, m_tgt);
            chk("R6", "new_sp", new_sp, (m_sp - PB) & 16'hFFFF);
        end
        // model update
        if (m_phase == 0) begin
            if (acc) begin
                m_phase = 1;
                m_pc = int'(pc);
                m_sp = int'(sp);
                m_tgt = int'(VB) + (rst_req ? 0 : (low + 1)) * (LJ ? 2 : 1);
            end
        end else if (m_phase == PB + 1) m_phase = 0;
        else m_phase++;
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state (R9, R7)
        run(2);
        // R1: pending and reset requests with enable low are ignored
        gie = 0; pend = 8'h81; rst_req = 1; pc = 22'h123456; sp = 16'h0800;
        run(4);
        rst_req = 0;
        run(2);
        // R8: skip pending blocks acceptance
        gie = 1; skip = 1;
        run(3);
        // R3/R4/R5: lowest bit wins (bit 0 -> vector 1)
        skip = 0; pend = 8'h81; pc = 22'h3A5C7E;
        run(1);
        gie = 0; pend = 8'h80;     // core cleared bit 0; R9 inputs ignored while busy
        run(PB + 1);
        // R3: several bits, bit 2 wins (vector 3)
        gie = 1; pend = 8'hA4; pc = 22'h00BEEF; sp = 16'h1234;
        run(1);
        gie = 0; pend = 8'hA0;
        run(PB + 2);
        // R2: reset beats hardware, vector 0, no pending clear
        gie = 1; rst_req = 1; pend = 8'h10; pc = 22'h2ABCDE; sp = 16'h0100;
        run(1);
        rst_req = 0; gie = 0;
        run(PB + 1);
        // R5/R6: stack pointer wraps below zero; highest source (vector 8)
        gie = 1; pend = 8'h80; pc = 22'h1F0F0F; sp = 16'h0001;
        run(1);
        pend = 8'h40;              // back-to-back: enable stays high
        run(PB + 1);
        sp = 16'h0FFF; pc = 22'h000102;
        run(PB + 3);
        gie = 0; pend = 0;
        run(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule